// File: doc/BRIEF.md
# Programmable Logic Cell

This block models a single configurable cell of a programmable logic fabric. A 16-entry lookup table evaluates any function of four data inputs or, in arithmetic mode, a sum and a carry function of two data inputs and a carry arriving from the neighbouring cell. Beside it sits one storage bit that can behave as a D, T, JK or SR flip-flop.

Static configuration inputs pick the table contents, the flip-flop behaviour, and which of two shared clocks, enables and clear lines drive the register. They also pick where the register's data comes from: the table, the chain input from the previous cell, or a direct data pin in packing mode. Each of the three cell outputs (local, row, column) independently shows either the combinational table result or the stored bit. This allows pure combinational use, registered use, or packing, where the table and the register serve unrelated logic.

Shared synchronous clear and synchronous load controls, a chip-wide active-low reset, a carry output and a register-chain output complete the cell.

Top module: `logic_cell`

## Requirements
- R1: With `cfg_arith`=0 the table result is `cfg_mask[{din[3],din[2],din[1],din[0]}]`, and `cout` is 0.
- R2: With `cfg_arith`=1 the table result is `cfg_mask[{0,cin,din[1],din[0]}]`, and `cout` is `cfg_mask[{1,cin,din[1],din[0]}]`.
- R3: Each bit of `cfg_out_reg` (bit 0 local, bit 1 row, bit 2 column) selects the register (1) or the table result (0) for that output. `chain_out` always shows the register.
- R4: `cfg_mode` encodes 0=D, 1=T, 2=JK, 3=SR. T toggles when `din[0]`=1. In JK and SR modes, `din[0]` is J/S and `din[1]` is K/R. JK with both high toggles. SR with both high holds.
- R5: Outside packing mode, the D input is `chain_in` when `cfg_chain`=1 and the table result otherwise.
- R6: With `cfg_pack`=1 the D input is `din[3]`, and `sload` has no effect.
- R7: On an enabled edge, `sclr` forces 0. Otherwise `sload` loads `din[2]`. Otherwise the mode logic applies.
- R8: `cfg_ena_sel` picks `ena_b` (1) or `ena_a` (0). When the picked enable is low, the register holds.
- R9: `cfg_clk_sel` picks `clk_b` (1) or `clk_a` (0) as the register clock. Edges on the other clock have no effect.
- R10: The clear line picked by `cfg_clr_sel` (`aclr_b` if 1, `aclr_a` if 0, active high) or `rst_n` low clears the register at once, whatever the enable. The other clear line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Shared clock source A |
| clk_b | input | 1 | Shared clock source B |
| ena_a | input | 1 | Shared clock enable A |
| ena_b | input | 1 | Shared clock enable B |
| aclr_a | input | 1 | Shared asynchronous clear A, active high |
| aclr_b | input | 1 | Shared asynchronous clear B, active high |
| rst_n | input | 1 | Chip-wide asynchronous reset, active low |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load of din[2] |
| din | input | 4 | Cell data inputs |
| cin | input | 1 | Carry from previous cell |
| chain_in | input | 1 | Register chain from previous cell |
| cfg_mask | input | 16 | Lookup table contents |
| cfg_arith | input | 1 | Arithmetic mode |
| cfg_mode | input | 2 | Flip-flop behaviour |
| cfg_clk_sel | input | 1 | Clock source select |
| cfg_ena_sel | input | 1 | Enable source select |
| cfg_clr_sel | input | 1 | Clear line select |
| cfg_chain | input | 1 | D input from register chain |
| cfg_pack | input | 1 | Register packing mode |
| cfg_out_reg | input | 3 | Per-output register select |
| out_local | output | 1 | Local output |
| out_row | output | 1 | Row output |
| out_col | output | 1 | Column output |
| cout | output | 1 | Carry to next cell |
| chain_out | output | 1 | Register chain to next cell |

## Verification
The stored bit is the only state. A wrong next-state decision in any mode or priority shows on `chain_out`, and on any output routed to the register, right after the next selected clock edge. Because the bit feeds the T, JK and SR hold terms, the error then spreads into later cycles. Table and output-selection faults are combinational and show in the same cycle the inputs change. Clear faults show without any clock edge. Random configurations are compared every cycle against a reference model, and directed cases cover clock and clear selection and the priorities between controls.

// File: rtl/logic_cell.sv
module logic_cell (
  input  logic        clk_a,
  input  logic        clk_b,
  input  logic        ena_a,
  input  logic        ena_b,
  input  logic        aclr_a,
  input  logic        aclr_b,
  input  logic        rst_n,
  input  logic        sclr,
  input  logic        sload,
  input  logic [3:0]  din,
  input  logic        cin,
  input  logic        chain_in,
  input  logic [15:0] cfg_mask,
  input  logic        cfg_arith,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_clk_sel,
  input  logic        cfg_ena_sel,
  input  logic        cfg_clr_sel,
  input  logic        cfg_chain,
  input  logic        cfg_pack,
  input  logic [2:0]  cfg_out_reg,
  output logic        out_local,
  output logic        out_row,
  output logic        out_col,
  output logic        cout,
  output logic        chain_out
);

  typedef enum logic [1:0] {FF_D = 2'd0, FF_T = 2'd1, FF_JK = 2'd2, FF_SR = 2'd3} ff_kind_e;

  logic       reg_clk, reg_ena, reg_clr;
  logic       q, q_next, mode_next, d_src, lut_out;
  logic [2:0] ar_idx;

  assign reg_clk = cfg_clk_sel ? clk_b : clk_a;
  assign reg_ena = cfg_ena_sel ? ena_b : ena_a;
  assign reg_clr = (cfg_clr_sel ? aclr_b : aclr_a) | ~rst_n;

  assign ar_idx  = {cin, din[1], din[0]};
  assign lut_out = cfg_arith ? cfg_mask[{1'b0, ar_idx}] : cfg_mask[din];
  assign cout    = cfg_arith & cfg_mask[{1'b1, ar_idx}];

  assign d_src = cfg_pack ? din[3] : (cfg_chain ? chain_in : lut_out);

  always_comb begin
    case (ff_kind_e'(cfg_mode))
      FF_D:    mode_next = d_src;
      FF_T:    mode_next = q ^ din[0];
      FF_JK:   mode_next = din[0] & din[1] ? ~q : (din[0] | (q & ~din[1]));
      default: mode_next = din[0] & din[1] ? q : (din[0] | (q & ~din[1]));
    endcase
  end

  always_comb begin
    if (sclr)                  q_next = 1'b0;
    else if (sload && !cfg_pack) q_next = din[2];
    else                       q_next = mode_next;
  end

  always_ff @(posedge reg_clk or posedge reg_clr) begin
    if (reg_clr)      q <= 1'b0;
    else if (reg_ena) q <= q_next;
  end

  assign out_local = cfg_out_reg[0] ? q : lut_out;
  assign out_row   = cfg_out_reg[1] ? q : lut_out;
  assign out_col   = cfg_out_reg[2] ? q : lut_out;
  assign chain_out = q;

  AST_CLEAR_HOLDS: assert property (@(posedge reg_clk) reg_clr |-> !chain_out); // R10
  AST_SCLR_WINS: assert property (@(posedge reg_clk) disable iff (reg_clr)
    reg_ena && sclr |=> !chain_out); // R7
  AST_NO_ENA_HOLD: assert property (@(posedge reg_clk) disable iff (reg_clr)
    !reg_ena |=> $stable(chain_out)); // R8
  AST_SLOAD_DATA: assert property (@(posedge reg_clk) disable iff (reg_clr)
    reg_ena && !sclr && sload && !cfg_pack |=> chain_out == $past(din[2])); // R7
  AST_PACK_DATA: assert property (@(posedge reg_clk) disable iff (reg_clr)
    reg_ena && !sclr && cfg_pack && cfg_mode == 2'd0 |=> chain_out == $past(din[3])); // R6
  AST_SR_BOTH_HOLD: assert property (@(posedge reg_clk) disable iff (reg_clr)
    reg_ena && !sclr && !(sload && !cfg_pack) && cfg_mode == 2'd3 && din[0] && din[1]
    |=> $stable(chain_out)); // R4

endmodule

// File: tb/logic_cell_tb.sv
module logic_cell_tb_top;
  localparam int PERIOD = 10;

  logic clk_a = 1'b0, clkb_gate = 1'b0, clk_b;
  logic ena_a, ena_b, aclr_a, aclr_b, rst_n, sclr, sload, cin, chain_in;
  logic [3:0] din;
  logic [15:0] cfg_mask;
  logic cfg_arith, cfg_clk_sel, cfg_ena_sel, cfg_clr_sel, cfg_chain, cfg_pack;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_out_reg;
  logic out_local, out_row, out_col, cout, chain_out;
  int checks = 0, errors = 0;
  bit q_m = 1'b0;

  always #(PERIOD/2) clk_a = ~clk_a;
  assign clk_b = clk_a & clkb_gate;

  logic_cell dut_i (.*);

  function automatic bit lut_ref();
    return cfg_arith ? cfg_mask[{1'b0, cin, din[1], din[0]}] : cfg_mask[din];
  endfunction

  function automatic bit next_ref(bit q);
    bit d;
    d = cfg_pack ? din[3] : (cfg_chain ? chain_in : lut_ref());
    if (sclr) return 1'b0;
    if (sload && !cfg_pack) return din[2];
    case (cfg_mode)
      2'd0: return d;
      2'd1: return q ^ din[0];
      2'd2: return (din[0] && din[1]) ? ~q : (din[0] ? 1'b1 : (din[1] ? 1'b0 : q));
      default: return (din[0] && din[1]) ? q : (din[0] ? 1'b1 : (din[1] ? 1'b0 : q));
    endcase
  endfunction

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit l = lut_ref();
    check(out_local, cfg_out_reg[0] ? q_m : l, cfg_arith ? "R2 R3 local" : "R1 R3 local");
    check(out_row,   cfg_out_reg[1] ? q_m : l, "R3 row");
    check(out_col,   cfg_out_reg[2] ? q_m : l, "R3 col");
    check(cout, cfg_arith ? cfg_mask[{1'b1, cin, din[1], din[0]}] : 1'b0, "R1 R2 cout");
    check(chain_out, q_m, "R4 R5 R6 R7 R8 register");
  endtask

  task automatic tick();
    bit nq = next_ref(q_m);
    bit en = cfg_ena_sel ? ena_b : ena_a;
    bit edge_ok = !cfg_clk_sel || clkb_gate;
    @(posedge clk_a);
    if (en && edge_ok) q_m = nq;
    @(negedge clk_a);
    #1;
  endtask

  task automatic quiet();
    ena_a = 1; ena_b = 1; aclr_a = 0; aclr_b = 0; sclr = 0; sload = 0;
    cfg_clk_sel = 0; cfg_ena_sel = 0; cfg_clr_sel = 0; cfg_chain = 0; cfg_pack = 0;
    cfg_arith = 0; cfg_mode = 0; cfg_out_reg = 3'b111;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    quiet();
    rst_n = 0; din = 0; cin = 0; chain_in = 0; cfg_mask = 16'h0;
    @(negedge clk_a); #1;
    check(chain_out, 1'b0, "R10 reset clears");
    rst_n = 1;

    // R6: packing loads din[3], sload ignored
    cfg_pack = 1; din = 4'b1000; sload = 1; tick();
    check(chain_out, 1'b1, "R6 pack ignores sload");
    // R7: sclr beats sload, sload beats mode
    cfg_pack = 0; sclr = 1; sload = 1; din = 4'b0100; tick();
    check(chain_out, 1'b0, "R7 sclr priority");
    sclr = 0; tick();
    check(chain_out, 1'b1, "R7 sload loads din2");
    // R8: low selected enable holds, other enable ignored
    sload = 0; sclr = 1; cfg_ena_sel = 1; ena_b = 0; ena_a = 1; tick();
    check(chain_out, 1'b1, "R8 enable low holds");
    ena_b = 1; tick();
    check(chain_out, 1'b0, "R8 enable b selected");
    // R4: SR both high holds, JK both high toggles
    sclr = 0; cfg_mode = 2'd3; din = 4'b0001; tick();
    din = 4'b0011; tick();
    check(chain_out, 1'b1, "R4 SR both high hold");
    cfg_mode = 2'd2; tick();
    check(chain_out, 1'b0, "R4 JK both high toggle");
    // R5: chain input source
    cfg_mode = 0; cfg_chain = 1; chain_in = 1; tick();
    check(chain_out, 1'b1, "R5 chain source");
    // R9: clock b selected but silent; clock a edges ignored
    chain_in = 0; cfg_clk_sel = 1; tick(); tick();
    check(chain_out, 1'b1, "R9 unselected clock ignored");
    clkb_gate = 1; tick();
    check(chain_out, 1'b0, "R9 clock b drives register");
    clkb_gate = 0; cfg_clk_sel = 0;
    // R10: selected clear acts with no edge; other line ignored
    chain_in = 1; tick();
    cfg_clr_sel = 1; ena_b = 0; aclr_a = 1; #1;
    check(chain_out, 1'b1, "R10 unselected clear ignored");
    aclr_a = 0; aclr_b = 1; #1;
    check(chain_out, 1'b0, "R10 selected clear immediate");
    aclr_b = 0; q_m = 0; ena_b = 1; #1;

    for (int i = 0; i < 600; i++) begin
      {cfg_mask} = 16'($urandom);
      {cfg_arith, cfg_ena_sel, cfg_chain, cfg_pack} = 4'($urandom);
      cfg_mode = 2'($urandom); cfg_out_reg = 3'($urandom);
      din = 4'($urandom); {cin, chain_in, ena_a, ena_b} = 4'($urandom);
      sclr = ($urandom % 8) == 0; sload = ($urandom % 6) == 0;
      #1;
      check_outputs();
      tick();
    end
    check_outputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule